// File: doc/BRIEF.md
# Frame Step Sequencer

This block sets the slow rhythm of a sound generator. It counts enabled CPU clock cycles and, once per step interval, advances through a short list of steps. Each step can send a quarter-frame tick (used by envelopes and linear counters) and a half-frame tick (used by length counters). Two sequence lengths exist: a four-step frame and a five-step frame whose last step is silent. In the four-step frame, the first step also raises a frame interrupt flag.

Software controls the block through a single control write. Bit 7 of the written byte picks the frame length and bit 6 is the interrupt enable. A status read clears the interrupt flag. A region select input picks one of two step intervals. The tick outputs are one clock wide. The channels that consume the ticks are outside this block.

Top module: `frame_step_sequencer`

## Requirements
- R1: After reset, both ticks and the interrupt flag are low, the frame is four steps long, and the first step to fire is step 0.
- R2: Only cycles with `cpu_en` high are counted. The count starts at 0. A step fires when the incremented count would exceed the interval, and the interval is then subtracted. So the first step comes PERIOD+1 enabled cycles after the count was cleared, and each later step comes PERIOD enabled cycles after the one before.
- R3: `pal_sel` = 0 selects the interval `NTSC_PERIOD` and `pal_sel` = 1 selects `PAL_PERIOD`.
- R4: In the four-step frame the steps run 0,1,2,3 and then return to 0. Every step gives a quarter tick. Steps 0 and 2 also give a half tick.
- R5: In the five-step frame the steps run 0,1,2,3,4 and then return to 0. Step 4 gives no tick.
- R6: Step 0 of the four-step frame sets the interrupt flag whatever the enable is. The five-step frame never sets it.
- R7: A control write clears the cycle count. With bit 7 = 0 it selects the four-step frame, gives no tick, and makes step 1 the next step to fire.
- R8: A control write with bit 7 = 1 selects the five-step frame and runs step 0 at once. Both ticks appear in the clock after the write, and step 1 is the next step to fire.
- R9: A control write with bit 6 = 0 clears the interrupt flag. With bit 6 = 1 the flag is left as it is.
- R10: A status read clears the interrupt flag. If a step sets the flag in the same cycle, the set wins.
- R11: Ticks are one-clock pulses, registered one clock after the event that causes them, and a half tick always comes with a quarter tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_en | input | 1 | CPU clock enable; only these cycles are counted |
| ctrl_wr | input | 1 | Write strobe for the frame control register |
| ctrl_wdata | input | 8 | Write data; bit 7 = five-step frame, bit 6 = interrupt enable |
| status_rd | input | 1 | Status read strobe; clears the interrupt flag |
| pal_sel | input | 1 | Interval select: 0 = NTSC_PERIOD, 1 = PAL_PERIOD |
| quarter_tick | output | 1 | Quarter-frame tick pulse |
| half_tick | output | 1 | Half-frame tick pulse |
| frame_irq | output | 1 | Frame interrupt flag |

## Verification
The sequencer runs under four patterns: free running after reset, with `cpu_en` high only on every third cycle, with the longer interval selected, and after each kind of control write. Every cycle is compared with a step schedule that the bench works out itself. Free running exposes off-by-one errors in the exceed-then-subtract count and mistakes in the step order. The gated clock enable shows whether disabled cycles are wrongly counted. The two kinds of control write tell apart the restart rules, including whether step 0 fires at once and which step follows. The strobe tests place a status read exactly on the cycle in which step 0 fires, which exposes the wrong priority between setting and clearing the flag, and also check that control writes keep or clear the flag according to bit 6.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  localparam int STEP_W         = 3;
  localparam int CTRL_FIVE_BIT  = 7;
  localparam int CTRL_IRQEN_BIT = 6;

  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic {
    MODE_FOUR = 1'b0,
    MODE_FIVE = 1'b1
  } seq_mode_e;

  // steps 0..3 drive the quarter-frame tick, step 4 is silent
  function automatic logic step_quarter(step_t s);
    return s < step_t'(4);
  endfunction

  // even steps among 0..3 also drive the half-frame tick
  function automatic logic step_half(step_t s);
    return (s < step_t'(4)) && !s[0];
  endfunction

  function automatic step_t step_after(step_t s, seq_mode_e m);
    step_t last;
    last = (m == MODE_FIVE) ? step_t'(4) : step_t'(3);
    return (s >= last) ? step_t'(0) : step_t'(s + step_t'(1));
  endfunction

  function automatic logic step_raises_irq(step_t s, seq_mode_e m);
    return (s == step_t'(0)) && (m == MODE_FOUR);
  endfunction

endpackage

// File: rtl/frame_cycle_counter.sv
module frame_cycle_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_en,
  input  logic             clear,
  input  logic [CNT_W-1:0] period,
  output logic             fire,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] inc;

  always_comb begin
    inc  = count + CNT_W'(1);
    fire = cpu_en && !clear && (inc > period);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= '0;
    end else if (cpu_en) begin
      count <= fire ? (inc - period) : inc;
    end
  end

endmodule

// File: rtl/frame_step_ctrl.sv
module frame_step_ctrl
  import frame_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fire,
  input  logic      wr,
  input  logic      wr_five,
  output step_t     step,
  output seq_mode_e mode,
  output logic      irq_set,
  output logic      quarter_tick,
  output logic      half_tick
);

  logic  exec;
  step_t exec_step;

  always_comb begin
    // a control write overrides any count-driven step in the same cycle
    exec      = wr ? wr_five : fire;
    exec_step = wr ? step_t'(0) : step;
    irq_set   = fire && step_raises_irq(step, mode);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step         <= '0;
      mode         <= MODE_FOUR;
      quarter_tick <= 1'b0;
      half_tick    <= 1'b0;
    end else begin
      quarter_tick <= exec && step_quarter(exec_step);
      half_tick    <= exec && step_half(exec_step);
      if (wr) begin
        step <= step_t'(1);
        mode <= wr_five ? MODE_FIVE : MODE_FOUR;
      end else if (fire) begin
        step <= step_after(step, mode);
      end
    end
  end

endmodule

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_irq_en,
  input  logic rd,
  input  logic irq_set,
  output logic irq_flag
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
    end else if (irq_set) begin
      irq_flag <= 1'b1;
    end else if ((wr && !wr_irq_en) || rd) begin
      irq_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/frame_step_sequencer.sv
module frame_step_sequencer
  import frame_seq_pkg::*;
#(
  parameter int NTSC_PERIOD = 7458,
  parameter int PAL_PERIOD  = 8314
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_en,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_wdata,
  input  logic       status_rd,
  input  logic       pal_sel,
  output logic       quarter_tick,
  output logic       half_tick,
  output logic       frame_irq
);

  localparam int MAX_PERIOD = (PAL_PERIOD > NTSC_PERIOD) ? PAL_PERIOD : NTSC_PERIOD;
  localparam int CNT_W      = $clog2(MAX_PERIOD + 2);

  logic [CNT_W-1:0] period_sel;
  logic [CNT_W-1:0] cycle_count;
  logic             step_fire;
  logic             irq_set;
  step_t            step_idx;
  seq_mode_e        seq_mode;
  logic             ctrl_unused;

  assign period_sel  = pal_sel ? CNT_W'(PAL_PERIOD) : CNT_W'(NTSC_PERIOD);
  assign ctrl_unused = ^ctrl_wdata[5:0];

  frame_cycle_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .cpu_en(cpu_en),
    .clear (ctrl_wr),
    .period(period_sel),
    .fire  (step_fire),
    .count (cycle_count)
  );

  frame_step_ctrl u_steps (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (step_fire),
    .wr          (ctrl_wr),
    .wr_five     (ctrl_wdata[CTRL_FIVE_BIT]),
    .step        (step_idx),
    .mode        (seq_mode),
    .irq_set     (irq_set),
    .quarter_tick(quarter_tick),
    .half_tick   (half_tick)
  );

  frame_irq_ctrl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctrl_wr),
    .wr_irq_en(ctrl_wdata[CTRL_IRQEN_BIT]),
    .rd       (status_rd),
    .irq_set  (irq_set),
    .irq_flag (frame_irq)
  );

endmodule

// File: rtl/frame_seq_checker.sv
module frame_seq_checker
  import frame_seq_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_en,
  input logic             ctrl_wr,
  input logic [7:0]       ctrl_wdata,
  input logic             status_rd,
  input logic             quarter_tick,
  input logic             half_tick,
  input logic             frame_irq,
  input logic             step_fire,
  input logic             irq_set,
  input step_t            step_idx,
  input seq_mode_e        seq_mode,
  input logic [CNT_W-1:0] cycle_count
);

  assert_half_implies_quarter_R11: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> quarter_tick);

  assert_fire_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> cpu_en);

  assert_write_clears_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (cycle_count == '0));

  assert_four_write_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctrl_wdata[7]) |=> !quarter_tick);

  assert_five_write_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata[7]) |=> (quarter_tick && half_tick));

  assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode == MODE_FIVE) ? (step_idx <= step_t'(4)) : (step_idx <= step_t'(3)));

  assert_four_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && seq_mode == MODE_FOUR && step_idx == step_t'(3)) |=> (step_idx == step_t'(0)));

  assert_five_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode == MODE_FIVE && !frame_irq) |=> !frame_irq);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !irq_set) |=> !frame_irq);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> frame_irq);

endmodule

bind frame_step_sequencer frame_seq_checker #(
  .CNT_W(CNT_W)
) u_frame_seq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_en      (cpu_en),
  .ctrl_wr     (ctrl_wr),
  .ctrl_wdata  (ctrl_wdata),
  .status_rd   (status_rd),
  .quarter_tick(quarter_tick),
  .half_tick   (half_tick),
  .frame_irq   (frame_irq),
  .step_fire   (step_fire),
  .irq_set     (irq_set),
  .step_idx    (step_idx),
  .seq_mode    (seq_mode),
  .cycle_count (cycle_count)
);

// File: tb/test_frame_step_sequencer.sv
`timescale 1ns/1ps
module test_frame_step_sequencer;

  localparam int PN = 10;
  localparam int PP = 13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_en = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       status_rd = 1'b0;
  logic       pal_sel = 1'b0;
  logic       quarter_tick;
  logic       half_tick;
  logic       frame_irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  frame_step_sequencer #(
    .NTSC_PERIOD(PN),
    .PAL_PERIOD (PP)
  ) i_frame_step_sequencer (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_en      (cpu_en),
    .ctrl_wr     (ctrl_wr),
    .ctrl_wdata  (ctrl_wdata),
    .status_rd   (status_rd),
    .pal_sel     (pal_sel),
    .quarter_tick(quarter_tick),
    .half_tick   (half_tick),
    .frame_irq   (frame_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // leaves the bench at a falling edge with the count cleared
  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_en = 1'b0; ctrl_wr = 1'b0; status_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ctrl_write(input logic [7:0] d);
    ctrl_wr = 1'b1; ctrl_wdata = d; cpu_en = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  // steps through n edges after a clearing event and compares every cycle
  task automatic watch(input int n, input int per, input int first_step, input bit five,
                       input int gap, input bit irq_start, input string tag);
    int en_cnt = 0;
    int nsteps = five ? 5 : 4;
    bit exp_irq = irq_start;
    for (int j = 1; j <= n; j++) begin
      bit en = (j % gap) == 0;
      bit exp_q = 1'b0;
      bit exp_h = 1'b0;
      cpu_en = en;
      @(negedge clk);
      if (en) begin
        en_cnt++;
        if (en_cnt >= per + 1 && ((en_cnt - per - 1) % per) == 0) begin
          int s = (first_step + (en_cnt - per - 1) / per) % nsteps;
          exp_q = s < 4;
          exp_h = (s < 4) && (s % 2 == 0);
          if (s == 0 && !five) exp_irq = 1'b1;
        end
      end
      chk({tag, " quarter"}, int'(quarter_tick), int'(exp_q));
      chk({tag, " half"}, int'(half_tick), int'(exp_h));
      chk({tag, " irq"}, int'(frame_irq), int'(exp_irq));
      chk("R11 half without quarter", int'(half_tick && !quarter_tick), 0);
    end
  endtask

  task automatic t_reset_four();
    apply_reset();
    chk("R1 reset quarter", int'(quarter_tick), 0);
    chk("R1 reset half", int'(half_tick), 0);
    chk("R1 reset irq", int'(frame_irq), 0);
    watch(6 * PN + 2, PN, 0, 1'b0, 1, 1'b0, "R4 R6 free run");
  endtask

  task automatic t_gated_enable();
    apply_reset();
    watch(3 * (5 * PN + 2), PN, 0, 1'b0, 3, 1'b0, "R2 gated cpu_en");
  endtask

  task automatic t_pal();
    pal_sel = 1'b1;
    apply_reset();
    watch(5 * PP + 2, PP, 0, 1'b0, 1, 1'b0, "R3 pal interval");
    pal_sel = 1'b0;
  endtask

  task automatic t_write_four();
    apply_reset();
    watch(3, PN, 0, 1'b0, 1, 1'b0, "R7 pre-write");
    ctrl_write(8'h00);
    chk("R7 no immediate tick", int'(quarter_tick), 0);
    watch(5 * PN + 2, PN, 1, 1'b0, 1, 1'b0, "R7 four-step restart");
  endtask

  task automatic t_write_five();
    apply_reset();
    watch(PN - 2, PN, 0, 1'b0, 1, 1'b0, "R8 pre-write");
    ctrl_write(8'h80);
    chk("R8 immediate quarter", int'(quarter_tick), 1);
    chk("R8 immediate half", int'(half_tick), 1);
    watch(11 * PN + 1, PN, 1, 1'b1, 1, 1'b0, "R5 R6 five-step");
  endtask

  task automatic t_irq_enable();
    apply_reset();
    watch(PN + 1, PN, 0, 1'b0, 1, 1'b0, "R9 flag raise");
    ctrl_write(8'h40);
    chk("R9 enable keeps flag", int'(frame_irq), 1);
    ctrl_write(8'h00);
    chk("R9 disable clears flag", int'(frame_irq), 0);
  endtask

  task automatic t_status_read();
    apply_reset();
    watch(PN, PN, 0, 1'b0, 1, 1'b0, "R10 run-up");
    status_rd = 1'b1; cpu_en = 1'b1;
    @(negedge clk);
    chk("R10 set wins over read", int'(frame_irq), 1);
    chk("R10 step 0 tick", int'(quarter_tick), 1);
    @(negedge clk);
    chk("R10 read clears flag", int'(frame_irq), 0);
    status_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_four();
    t_gated_enable();
    t_pal();
    t_write_four();
    t_write_five();
    t_irq_enable();
    t_status_read();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule